// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block gathers the interrupt events of a four-channel DMA engine. There are five event types: transfer done, block done, source transaction done, destination transaction done, and error. Each channel engine sends single-cycle event pulses. For each type the block keeps one latched raw bit per channel and one enable (mask) bit per channel. The masked status is the AND of those two bits.

Software reaches the state through a flat 32-bit register port. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`.

The address map uses aligned word slots 8 bytes apart. The type order within each group is transfer, block, source, destination, error, so type t sits at base + 8·t:

| Group | Base offset | Access |
|---|---|---|
| Raw | 0x00 | read-only |
| Masked status | 0x28 | read-only |
| Mask | 0x50 | read-write |
| Clear | 0x78 | write-only |
| Summary word | 0xA0 | read-only |

A single interrupt line is the OR of everything in the summary word, gated by a global enable input.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every raw bit and every mask bit is 0. Every offset reads 0 and `irq` is low.
- R2: Event bit `evt_pulse[t*4+n]` sets raw bit n of type t at the next clock edge. The bit stays set until it is cleared. It reads back at bit n of offset 0x00+8·t, with bits 31:4 read as 0.
- R3: A write to mask offset 0x50+8·t loads bit n of the mask from wdata bit n only when wdata bit 8+n is 1. Otherwise that mask bit keeps its value. A mask read returns the four mask bits in bits 3:0 and 0 everywhere else. A value of 1 means the channel is enabled.
- R4: Offset 0x28+8·t reads raw AND mask for type t. Writes to these offsets change nothing.
- R5: Writing 1 to bit n at clear offset 0x78+8·t clears raw bit n of type t, and with it the masked status. Bits written as 0 leave state unchanged. Clear offsets read 0.
- R6: If an event pulse and a clear for the same bit arrive in the same cycle, the bit ends set.
- R7: Offset 0xA0 reads one bit per type in bits 4:0 (0 transfer, 1 block, 2 source, 3 destination, 4 error). Each bit is the OR of that type's four masked-status bits.
- R8: `irq` is high exactly when `irq_en` is high and at least one masked-status bit is set.
- R9: An offset that is not 8-byte aligned, or that is above 0xA0, reads 0. Writes to raw, status, summary or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Global gate for the interrupt line |
| evt_pulse | input | 20 | Event pulses, bit t*4+n = type t, channel n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: four channels, five types and an 8-bit offset. At that size every combination of mask value and enable nibble can be written to every type (1280 writes), each followed by a readback. Single and grouped event pulses and clear patterns are applied on top of that. After each step all 256 byte offsets are read and compared with a map computed in the bench. This covers misaligned and unmapped offsets as well as every mapped one. The bench also writes all-ones to every read-only and unmapped offset, then checks that nothing moved.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NUM_CH   = 4;
    localparam int NUM_TYPE = 5;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int WE_LSB   = 8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RAW,
        ACC_STAT,
        ACC_MASK,
        ACC_CLR,
        ACC_SUM
    } acc_kind_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import dma_irq_pkg::*;
#(
    parameter int NTYPE = NUM_TYPE,
    parameter int AW    = ADDR_W,
    parameter int TW    = (NTYPE > 1) ? $clog2(NTYPE) : 1
) (
    input  logic [AW-1:0] addr,
    output acc_kind_e     kind,
    output logic [TW-1:0] tsel
);
    localparam int SLOT_LG = 3;
    logic [AW-SLOT_LG-1:0] slot;
    int unsigned           s;

    assign slot = addr[AW-1:SLOT_LG];

    always_comb begin
        kind = ACC_NONE;
        tsel = '0;
        s    = 32'(slot);
        if (addr[SLOT_LG-1:0] == '0) begin
            if (s < NTYPE) begin
                kind = ACC_RAW;
                tsel = TW'(s);
            end else if (s < 2*NTYPE) begin
                kind = ACC_STAT;
                tsel = TW'(s - NTYPE);
            end else if (s < 3*NTYPE) begin
                kind = ACC_MASK;
                tsel = TW'(s - 2*NTYPE);
            end else if (s < 4*NTYPE) begin
                kind = ACC_CLR;
                tsel = TW'(s - 3*NTYPE);
            end else if (s == 4*NTYPE) begin
                kind = ACC_SUM;
            end
        end
    end
endmodule

// File: rtl/irq_type_bank.sv
module irq_type_bank
    import dma_irq_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int DW  = DATA_W,
    parameter int WEL = WE_LSB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic           mask_wr,
    input  logic           clr_wr,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] raw_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] stat
);
    logic [NCH-1:0] clr_bits;
    logic [NCH-1:0] we_bits;

    assign clr_bits = clr_wr  ? wdata[NCH-1:0]   : '0;
    assign we_bits  = mask_wr ? wdata[WEL +: NCH] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= evt | (raw_q & ~clr_bits);
            mask_q <= (mask_q & ~we_bits) | (wdata[NCH-1:0] & we_bits);
        end
    end

    assign stat = raw_q & mask_q;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int NTYPE = NUM_TYPE,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int WEL   = WE_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_en,
    input  logic [NTYPE*NCH-1:0] evt_pulse,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 irq
);
    localparam int TW = (NTYPE > 1) ? $clog2(NTYPE) : 1;

    acc_kind_e             kind;
    logic [TW-1:0]         tsel;
    logic [NCH-1:0]        raw_arr  [NTYPE];
    logic [NCH-1:0]        mask_arr [NTYPE];
    logic [NCH-1:0]        stat_arr [NTYPE];
    logic [NTYPE-1:0]      summary;
    logic [NTYPE*NCH-1:0]  raw_all;
    logic [NTYPE*NCH-1:0]  mask_all;

    irq_addr_decode #(.NTYPE(NTYPE), .AW(AW), .TW(TW)) u_dec (
        .addr (addr),
        .kind (kind),
        .tsel (tsel)
    );

    for (genvar g = 0; g < NTYPE; g++) begin : g_type
        logic hit;
        assign hit = wr_en && (int'(tsel) == g);

        irq_type_bank #(.NCH(NCH), .DW(DW), .WEL(WEL)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_pulse[g*NCH +: NCH]),
            .mask_wr (hit && (kind == ACC_MASK)),
            .clr_wr  (hit && (kind == ACC_CLR)),
            .wdata   (wdata),
            .raw_q   (raw_arr[g]),
            .mask_q  (mask_arr[g]),
            .stat    (stat_arr[g])
        );

        assign summary[g]               = |stat_arr[g];
        assign raw_all[g*NCH +: NCH]    = raw_arr[g];
        assign mask_all[g*NCH +: NCH]   = mask_arr[g];
    end

    always_comb begin
        rdata = '0;
        unique case (kind)
            ACC_RAW:  rdata[NCH-1:0]   = raw_arr[tsel];
            ACC_STAT: rdata[NCH-1:0]   = stat_arr[tsel];
            ACC_MASK: rdata[NCH-1:0]   = mask_arr[tsel];
            ACC_SUM:  rdata[NTYPE-1:0] = summary;
            ACC_CLR,
            ACC_NONE: rdata = '0;
            default:  rdata = '0;
        endcase
    end

    assign irq = irq_en && (|summary);
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
    parameter int NCH   = 4,
    parameter int NTYPE = 5,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_en,
    input logic [NTYPE*NCH-1:0] evt_pulse,
    input logic                 wr_en,
    input logic [AW-1:0]        addr,
    input logic [DW-1:0]        rdata,
    input logic                 irq,
    input logic [NTYPE*NCH-1:0] raw_all,
    input logic [NTYPE*NCH-1:0] mask_all
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $rose(rst_n) |-> (raw_all == '0 && mask_all == '0)); // R1

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((raw_all & $past(evt_pulse)) == $past(evt_pulse))); // R2

    AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_all)); // R3

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((raw_all & $past(raw_all)) == $past(raw_all))); // R5

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && evt_pulse != '0) |=> ((raw_all & $past(evt_pulse)) == $past(evt_pulse))); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R8

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw_all & mask_all) != '0)); // R8

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[2:0] != 3'b000) |-> (rdata == '0)); // R9
endmodule

bind dma_irq_ctrl dma_irq_chk #(.NCH(NCH), .NTYPE(NTYPE), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .evt_pulse (evt_pulse),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq       (irq),
    .raw_all   (raw_all),
    .mask_all  (mask_all)
);

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
    localparam int NCH = 4;
    localparam int NT  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_en = 1'b0;
    logic [19:0]   evt_pulse = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int failures = 0;
    logic [3:0] raw_m  [NT];
    logic [3:0] mask_m [NT];

    always #2 clk = ~clk;

    dma_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .evt_pulse(evt_pulse),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_rd(input int a);
        int w;
        logic [31:0] r;
        r = '0;
        w = a / 8;
        if (a % 8 != 0) return '0;
        if (w < NT) r[3:0] = raw_m[w];
        else if (w < 2*NT) r[3:0] = raw_m[w-NT] & mask_m[w-NT];
        else if (w < 3*NT) r[3:0] = mask_m[w-2*NT];
        else if (w == 4*NT) begin
            for (int t = 0; t < NT; t++) r[t] = |(raw_m[t] & mask_m[t]);
        end
        return r;
    endfunction

    function automatic string tag_of(input int a);
        int w;
        w = a / 8;
        if (a % 8 != 0) return "R9";
        if (w < NT) return "R2";
        if (w < 2*NT) return "R4";
        if (w < 3*NT) return "R3";
        if (w < 4*NT) return "R5";
        if (w == 4*NT) return "R7";
        return "R9";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s addr=%02h got=%08h exp=%08h", tag, addr, got, exp);
        end
    endtask

    task automatic check_irq();
        logic e;
        e = 1'b0;
        for (int t = 0; t < NT; t++) e |= |(raw_m[t] & mask_m[t]);
        chk("R8", {31'b0, irq}, {31'b0, irq_en & e});
    endtask

    // read every byte offset and compare with the computed map
    task automatic sweep_rd(input string ctx, input logic use_r1);
        for (int a = 0; a < 256; a++) begin
            addr = 8'(a);
            #1;
            chk(use_r1 ? "R1" : tag_of(a), rdata, exp_rd(a));
        end
        check_irq();
        if (ctx.len() == 0) $display("empty context");
    endtask

    task automatic bwr(input int a, input logic [31:0] d, input logic [19:0] ev);
        int w;
        w = a / 8;
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); wdata = d; evt_pulse = ev;
        @(negedge clk);
        wr_en = 1'b0; evt_pulse = '0;
        if (a % 8 == 0 && w >= 2*NT && w < 3*NT)
            mask_m[w-2*NT] = (mask_m[w-2*NT] & ~d[11:8]) | (d[3:0] & d[11:8]);
        if (a % 8 == 0 && w >= 3*NT && w < 4*NT)
            raw_m[w-3*NT] = raw_m[w-3*NT] & ~d[3:0];
        for (int t = 0; t < NT; t++) raw_m[t] |= ev[t*4 +: 4];
    endtask

    task automatic pulse(input logic [19:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
        for (int t = 0; t < NT; t++) raw_m[t] |= ev[t*4 +: 4];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) begin raw_m[t] = '0; mask_m[t] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        sweep_rd("reset", 1'b1);
        chk("R1", {31'b0, irq}, 32'b0);

        // R3: every mask value with every enable nibble, per type
        for (int t = 0; t < NT; t++)
            for (int we = 0; we < 16; we++)
                for (int m = 0; m < 16; m++) begin
                    bwr(8'h50 + 8*t, {20'hFFFFF & 20'(m*37), 4'(we), 4'hA, 4'(m)}, '0);
                    addr = 8'(8'h50 + 8*t);
                    #1;
                    chk("R3", rdata, {28'b0, mask_m[t]});
                end

        // fixed masks per type, then single event pulses (R2, R4, R7, R8)
        irq_en = 1'b1;
        for (int t = 0; t < NT; t++) bwr(8'h50 + 8*t, {20'b0, 4'hF, 4'b0, 4'((t*3 + 5) % 16)}, '0);
        sweep_rd("masks", 1'b0);
        for (int i = 0; i < 20; i++) begin
            pulse(20'(1) << i);
            sweep_rd("pulse", 1'b0);
            // R5: clear it again with the matching clear bit
            bwr(8'h78 + 8*(i/4), 32'(1) << (i%4), '0);
            sweep_rd("clear", 1'b0);
        end

        // grouped pulses and partial clears, zero clear is a no-op (R5)
        pulse(20'hA5C3F);
        sweep_rd("group", 1'b0);
        for (int t = 0; t < NT; t++) begin
            bwr(8'h78 + 8*t, 32'h0, '0);
            sweep_rd("clr0", 1'b0);
            bwr(8'h78 + 8*t, 32'h5, '0);
            sweep_rd("clr5", 1'b0);
        end

        // R6: event and clear on the same bit in the same cycle
        bwr(8'h78, 32'hF, 20'h00001);
        addr = 8'h00; #1;
        chk("R6", rdata, 32'h1);
        bwr(8'h98, 32'hF, 20'h80000);
        addr = 8'h20; #1;
        chk("R6", rdata, 32'h8);
        sweep_rd("collide", 1'b0);

        // R8: global gate off with pending masked status
        pulse(20'hFFFFF);
        irq_en = 1'b0;
        #1;
        chk("R8", {31'b0, irq}, 32'b0);
        irq_en = 1'b1;
        #1;
        check_irq();

        // R9: writes of all-ones to read-only and unmapped offsets do nothing
        for (int a = 0; a < 256; a++) begin
            if (!(a % 8 == 0 && a >= 8'h50 && a < 8'hA0)) bwr(a, 32'hFFFFFFFF, '0);
        end
        sweep_rd("ro-writes", 1'b0);

        // clear everything and confirm the line drops (R5, R8)
        for (int t = 0; t < NT; t++) bwr(8'h78 + 8*t, 32'hF, '0);
        sweep_rd("final", 1'b0);
        chk("R8", {31'b0, irq}, 32'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule